// File: doc/BRIEF.md
# Instruction Cache Tag and Valid Controller

This block keeps the tag and valid state of a small direct-mapped instruction cache. It has 64 entries, and each entry holds one 32-bit long word. A fetch unit presents a lookup made of an address and a supervisor/user bit, and the block answers hit or miss in the same cycle. When a fill response comes back, the block allocates the matching entry by writing its tag and setting its valid bit. The data array itself is outside this block.

Supervisor software controls the cache through two registers on a plain read/write port:

- **Control register.** It holds an enable bit and a freeze bit. It also has two command bits that do not hold their value: one drops every entry, and the other drops the single entry named by the index register.
- **Index register.** It supplies the index for the single-entry drop.

An external disable input overrides the enable bit, so a debug or test environment can force every fetch to miss without touching software state.

Top module: `icache_ctl`

## Requirements
- R1: Reset clears the enable and freeze bits and leaves every entry invalid. After reset, both registers read 0 and every lookup misses.
- R2: The control register is selected with `reg_sel`=0. Its bit 0 is enable and its bit 1 is freeze, and a read returns the last values written to these two bits.
- R3: Control register bits 31:2 always read 0. Writes to bits 31:4 have no effect.
- R4: Writing a 1 to control bit 3 invalidates every entry at that clock edge. The bit reads back as 0.
- R5: Writing a 1 to control bit 2 invalidates only the entry whose index is held in the index register. This happens whatever the enable and freeze bits are, and the bit reads back as 0.
- R6: The index register is selected with `reg_sel`=1. It stores write-data bits 7:2 as the index and reads back with every other bit 0.
- R7: While `cache_off` is high or enable is 0, every lookup misses and fills allocate nothing.
- R8: While freeze is 1, lookups still report hits, but a fill allocates and replaces nothing.
- R9: The index is address bits 7:2. A lookup hits only when the indexed entry is valid and its stored address bits 31:8 and supervisor bit both equal those of the lookup.
- R10: If a clear-all write and a fill occur in the same cycle, the clear wins and the filled entry is left invalid.
- R11: Register writes and fills take effect at the next clock edge. `lk_hit` is combinational, so a lookup in the cycle after an invalidate or a fill already sees the new state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 = control, 1 = index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| cache_off | input | 1 | External disable; forces misses and blocks fills |
| lk_req | input | 1 | Lookup request |
| lk_addr | input | 32 | Lookup address |
| lk_super | input | 1 | Lookup supervisor/user bit |
| lk_hit | output | 1 | Lookup hit (same cycle) |
| fill_valid | input | 1 | Fill response strobe |
| fill_addr | input | 32 | Fill address |
| fill_super | input | 1 | Fill supervisor/user bit |

## Verification
A corrupt valid bit or stored tag shows at `lk_hit` on the first lookup of that index. The bench probes a hit in the cycle just after each fill or invalidate, so a missed or stale update appears one edge after the command that caused it. A lost enable or freeze bit shows on the next register read, and also on the next lookup or fill, which misses or allocates wrongly. A wrong index register clears the wrong entry, which the bench catches by probing both the target index and a neighbouring one.

// File: rtl/icache_pkg.sv
package icache_pkg;
    // Control register bit positions (software-visible layout)
    localparam int CTL_EN   = 0;
    localparam int CTL_FRZ  = 1;
    localparam int CTL_CLR1 = 2;
    localparam int CTL_CLRA = 3;

    typedef enum logic {
        SEL_CTRL = 1'b0,
        SEL_IDX  = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/icache_regs.sv
module icache_regs
    import icache_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 6,
    parameter int OFS_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              enable_o,
    output logic              freeze_o,
    output logic              clr_all_o,
    output logic              clr_one_o,
    output logic [IDX_W-1:0]  clr_idx_o
);
    localparam int HI_W = DATA_W - IDX_W - OFS_W;

    typedef struct packed {
        logic             enable;
        logic             freeze;
        logic [IDX_W-1:0] idx;
    } regs_t;

    regs_t r_d, r_q;
    logic  wr_ctrl, wr_idx;
    logic  unused_wbits;

    assign unused_wbits = ^wdata[DATA_W-1:IDX_W+OFS_W];

    always_comb begin
        wr_ctrl = wr_en && (sel == SEL_CTRL);
        wr_idx  = wr_en && (sel == SEL_IDX);
        r_d     = r_q;
        if (wr_ctrl) begin
            r_d.enable = wdata[CTL_EN];
            r_d.freeze = wdata[CTL_FRZ];
        end
        if (wr_idx) begin
            r_d.idx = wdata[IDX_W+OFS_W-1:OFS_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // Command bits act at the edge of the write; they are never stored
    assign clr_all_o = wr_ctrl && wdata[CTL_CLRA];
    assign clr_one_o = wr_ctrl && wdata[CTL_CLR1];
    assign clr_idx_o = r_q.idx;
    assign enable_o  = r_q.enable;
    assign freeze_o  = r_q.freeze;

    always_comb begin
        if (sel == SEL_CTRL) begin
            rdata = {{(DATA_W-2){1'b0}}, r_q.freeze, r_q.enable};
        end else begin
            rdata = {{HI_W{1'b0}}, r_q.idx, {OFS_W{1'b0}}};
        end
    end

    // R1: control bits are clear on the first edge after reset
    a_r1_reset_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!enable_o && !freeze_o));

    // R2: a control write is reflected in the stored enable bit next cycle
    a_r2_enable_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_CTRL) |=> (enable_o == $past(wdata[CTL_EN])));

    // R3: reserved and command bits read as zero
    a_r3_ctrl_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_CTRL) |-> (rdata[DATA_W-1:2] == '0));

    // R6: index register reads zero outside its field
    a_r6_idx_field_only: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_IDX) |-> (rdata[OFS_W-1:0] == '0 && rdata[DATA_W-1:IDX_W+OFS_W] == '0));
endmodule

// File: rtl/icache_store.sv
module icache_store #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 6,
    parameter int OFS_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              freeze,
    input  logic              lk_req,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic              lk_super,
    output logic              hit,
    input  logic              fill_valid,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic              fill_super,
    input  logic              clr_all,
    input  logic              clr_one,
    input  logic [IDX_W-1:0]  clr_idx
);
    localparam int ENTRIES = 1 << IDX_W;
    localparam int TAG_W   = ADDR_W - IDX_W - OFS_W + 1;

    typedef struct packed {
        logic [ENTRIES-1:0]            valid;
        logic [ENTRIES-1:0][TAG_W-1:0] tag;
    } store_t;

    store_t            s_d, s_q;
    logic [IDX_W-1:0]  lk_idx, f_idx;
    logic [TAG_W-1:0]  lk_tag, f_tag;
    logic              unused_ofs;

    assign unused_ofs = ^{lk_addr[OFS_W-1:0], fill_addr[OFS_W-1:0]};

    assign lk_idx = lk_addr[IDX_W+OFS_W-1:OFS_W];
    assign f_idx  = fill_addr[IDX_W+OFS_W-1:OFS_W];
    assign lk_tag = {lk_super, lk_addr[ADDR_W-1:IDX_W+OFS_W]};
    assign f_tag  = {fill_super, fill_addr[ADDR_W-1:IDX_W+OFS_W]};

    always_comb begin
        s_d = s_q;
        if (fill_valid && active && !freeze) begin
            s_d.valid[f_idx] = 1'b1;
            s_d.tag[f_idx]   = f_tag;
        end
        // Invalidations are applied last so they win over a same-cycle fill
        if (clr_one) begin
            s_d.valid[clr_idx] = 1'b0;
        end
        if (clr_all) begin
            s_d.valid = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign hit = lk_req && active && s_q.valid[lk_idx] && (s_q.tag[lk_idx] == lk_tag);

    // R1: no valid entry right after reset
    a_r1_reset_empty: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (s_q.valid == '0));

    // R4: clear-all leaves nothing valid
    a_r4_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> (s_q.valid == '0));

    // R5: the addressed entry is invalid after a clear-entry command
    a_r5_clear_one: assert property (@(posedge clk) disable iff (!rst_n)
        clr_one |=> !s_q.valid[$past(clr_idx)]);

    // R7: an inactive cache never gains a valid entry
    a_r7_no_alloc_inactive: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> ((s_q.valid & ~$past(s_q.valid)) == '0));

    // R8: a frozen cache never gains a valid entry
    a_r8_no_alloc_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |=> ((s_q.valid & ~$past(s_q.valid)) == '0));
endmodule

// File: rtl/icache_ctl.sv
module icache_ctl #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 6,
    parameter int OFS_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic              reg_sel,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    input  logic              cache_off,
    input  logic              lk_req,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic              lk_super,
    output logic              lk_hit,
    input  logic              fill_valid,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic              fill_super
);
    logic             enable, freeze, clr_all, clr_one, active;
    logic [IDX_W-1:0] clr_idx;

    icache_regs #(
        .DATA_W (ADDR_W),
        .IDX_W  (IDX_W),
        .OFS_W  (OFS_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_we),
        .sel       (reg_sel),
        .wdata     (reg_wdata),
        .rdata     (reg_rdata),
        .enable_o  (enable),
        .freeze_o  (freeze),
        .clr_all_o (clr_all),
        .clr_one_o (clr_one),
        .clr_idx_o (clr_idx)
    );

    // External disable overrides the software enable bit
    assign active = enable && !cache_off;

    icache_store #(
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W),
        .OFS_W  (OFS_W)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (active),
        .freeze     (freeze),
        .lk_req     (lk_req),
        .lk_addr    (lk_addr),
        .lk_super   (lk_super),
        .hit        (lk_hit),
        .fill_valid (fill_valid),
        .fill_addr  (fill_addr),
        .fill_super (fill_super),
        .clr_all    (clr_all),
        .clr_one    (clr_one),
        .clr_idx    (clr_idx)
    );

    // R7: the disable pin forces a miss
    a_r7_disable_miss: assert property (@(posedge clk) disable iff (!rst_n)
        cache_off |-> !lk_hit);

    // R9: a hit only answers a request
    a_r9_hit_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> lk_req);
endmodule

// File: tb/tb_icache_ctl.sv
module tb_icache_ctl;
    localparam logic [1:0] OP_WC = 2'd0, OP_WA = 2'd1, OP_FILL = 2'd2, OP_LOOK = 2'd3;

    typedef struct packed {
        logic [1:0]  op;
        logic [31:0] val;
        logic        sup;
        logic        exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VEC [NV] = '{
        '{OP_WC,   32'h0000_0001, 1'b0, 1'b0, 4'd2},
        '{OP_FILL, 32'h0000_1004, 1'b1, 1'b0, 4'd9},
        '{OP_LOOK, 32'h0000_1004, 1'b1, 1'b1, 4'd9},  // R9 hit
        '{OP_LOOK, 32'h0000_1004, 1'b0, 1'b0, 4'd9},  // R9 supervisor mismatch
        '{OP_LOOK, 32'h0000_2004, 1'b1, 1'b0, 4'd9},  // R9 tag mismatch
        '{OP_LOOK, 32'h0000_1008, 1'b1, 1'b0, 4'd9},  // R9 other index
        '{OP_FILL, 32'h0000_2008, 1'b0, 1'b0, 4'd9},
        '{OP_LOOK, 32'h0000_2008, 1'b0, 1'b1, 4'd11}, // R11 next-cycle hit
        '{OP_FILL, 32'h0000_3004, 1'b1, 1'b0, 4'd9},
        '{OP_LOOK, 32'h0000_1004, 1'b1, 1'b0, 4'd9},  // R9 replaced
        '{OP_LOOK, 32'h0000_3004, 1'b1, 1'b1, 4'd9},
        '{OP_WC,   32'h0000_0003, 1'b0, 1'b0, 4'd8},
        '{OP_LOOK, 32'h0000_3004, 1'b1, 1'b1, 4'd8},  // R8 hit while frozen
        '{OP_FILL, 32'h0000_40FC, 1'b1, 1'b0, 4'd8},
        '{OP_WC,   32'h0000_0001, 1'b0, 1'b0, 4'd8},
        '{OP_LOOK, 32'h0000_40FC, 1'b1, 1'b0, 4'd8},  // R8 frozen fill dropped
        '{OP_WA,   32'h0000_3004, 1'b0, 1'b0, 4'd6},
        '{OP_WC,   32'h0000_0007, 1'b0, 1'b0, 4'd5},
        '{OP_LOOK, 32'h0000_3004, 1'b1, 1'b0, 4'd5},  // R5 cleared while frozen
        '{OP_WC,   32'h0000_0001, 1'b0, 1'b0, 4'd5},
        '{OP_LOOK, 32'h0000_2008, 1'b0, 1'b1, 4'd5},  // R5 neighbour kept
        '{OP_FILL, 32'h0000_40FC, 1'b1, 1'b0, 4'd9},
        '{OP_LOOK, 32'h0000_40FC, 1'b1, 1'b1, 4'd9},
        '{OP_WC,   32'h0000_0009, 1'b0, 1'b0, 4'd4},
        '{OP_LOOK, 32'h0000_40FC, 1'b1, 1'b0, 4'd4},  // R4
        '{OP_LOOK, 32'h0000_2008, 1'b0, 1'b0, 4'd4}   // R4
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0, reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        cache_off = 1'b0;
    logic        lk_req = 1'b0, lk_super = 1'b0, lk_hit;
    logic [31:0] lk_addr = '0, fill_addr = '0;
    logic        fill_valid = 1'b0, fill_super = 1'b0;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    icache_ctl dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cache_off(cache_off),
        .lk_req(lk_req), .lk_addr(lk_addr), .lk_super(lk_super), .lk_hit(lk_hit),
        .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_super(fill_super)
    );

    task automatic check(input logic [31:0] got, input logic [31:0] exp, input int rq);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL R%0d: actual %h expected %h at %0t", rq, got, exp, $time);
        end
    endtask

    task automatic wr(input logic sel, input logic [31:0] d);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic fill(input logic [31:0] a, input logic s);
        fill_valid = 1'b1; fill_addr = a; fill_super = s;
        @(posedge clk); #1;
        fill_valid = 1'b0;
    endtask

    task automatic look(input logic [31:0] a, input logic s, input logic e, input int rq);
        lk_req = 1'b1; lk_addr = a; lk_super = s;
        #2;
        check({31'b0, lk_hit}, {31'b0, e}, rq);
        @(posedge clk); #1;
        lk_req = 1'b0;
    endtask

    task automatic rd(input logic sel, input logic [31:0] e, input int rq);
        reg_sel = sel;
        #2;
        check(reg_rdata, e, rq);
        @(posedge clk); #1;
    endtask

    initial begin
        #2_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state
        rd(1'b0, 32'h0, 1);
        rd(1'b1, 32'h0, 1);
        wr(1'b0, 32'h1);
        look(32'h0000_1004, 1'b1, 1'b0, 1);

        for (int i = 0; i < NV; i++) begin
            case (VEC[i].op)
                OP_WC:   wr(1'b0, VEC[i].val);
                OP_WA:   wr(1'b1, VEC[i].val);
                OP_FILL: fill(VEC[i].val, VEC[i].sup);
                default: look(VEC[i].val, VEC[i].sup, VEC[i].exp, int'(VEC[i].req));
            endcase
        end

        // R7: external disable forces miss and blocks fill
        fill(32'h0000_0500, 1'b0);
        look(32'h0000_0500, 1'b0, 1'b1, 7);
        cache_off = 1'b1;
        look(32'h0000_0500, 1'b0, 1'b0, 7);
        fill(32'h0000_0604, 1'b0);
        cache_off = 1'b0;
        look(32'h0000_0604, 1'b0, 1'b0, 7);
        look(32'h0000_0500, 1'b0, 1'b1, 7);
        // R7: enable bit clear behaves the same
        wr(1'b0, 32'h0);
        look(32'h0000_0500, 1'b0, 1'b0, 7);
        fill(32'h0000_0708, 1'b0);
        wr(1'b0, 32'h1);
        look(32'h0000_0708, 1'b0, 1'b0, 7);
        look(32'h0000_0500, 1'b0, 1'b1, 7);

        // R5: clear-entry acts while disabled
        wr(1'b1, 32'h0000_0500);
        wr(1'b0, 32'h4);
        wr(1'b0, 32'h1);
        look(32'h0000_0500, 1'b0, 1'b0, 5);

        // R10: clear-all and fill in the same cycle
        reg_we = 1'b1; reg_sel = 1'b0; reg_wdata = 32'h9;
        fill_valid = 1'b1; fill_addr = 32'h0000_080C; fill_super = 1'b1;
        @(posedge clk); #1;
        reg_we = 1'b0; fill_valid = 1'b0;
        look(32'h0000_080C, 1'b1, 1'b0, 10);

        // R2 / R3: field layout and ignored bits
        wr(1'b0, 32'hFFFF_FFF3);
        rd(1'b0, 32'h0000_0003, 3);
        wr(1'b0, 32'h0000_0002);
        rd(1'b0, 32'h0000_0002, 2);
        wr(1'b0, 32'h0000_000F);
        rd(1'b0, 32'h0000_0003, 3);
        // R6: index register field
        wr(1'b1, 32'hFFFF_FFFF);
        rd(1'b1, 32'h0000_00FC, 6);
        wr(1'b1, 32'h0000_0108);
        rd(1'b1, 32'h0000_0008, 6);

        // R1: reset in mid-run
        wr(1'b0, 32'h1);
        fill(32'h0000_0900, 1'b1);
        look(32'h0000_0900, 1'b1, 1'b1, 1);
        rst_n = 1'b0;
        @(posedge clk); #1;
        rst_n = 1'b1;
        rd(1'b0, 32'h0, 1);
        rd(1'b1, 32'h0, 1);
        wr(1'b0, 32'h1);
        look(32'h0000_0900, 1'b1, 1'b0, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule